// File: doc/BRIEF.md
# Rotating Segment Write-Start Selector

This block sits in front of a non-volatile memory array. It decides where compressed data is placed inside a 64-byte line. The line is split into four equal segments. Compressed data rarely fills all four, so always writing from segment 0 would wear the low segments much faster than the high ones. For every write, the selector picks the segment where the data begins and moves that start point around the line over time.

For each tracked line, the selector remembers whether the line has been written yet and which segment the previous write ended in. A new write is tried first at the segment just past that end. If the data does not fit from there without wrapping past the top of the line, the candidate start steps forward cyclically. Segment 0 always holds even a full-length line, so the search never fails. A line that is entirely zero is not placed at all: the selector reports a skip and leaves its memory of that line as it was.

The answer is registered. It appears on the cycle after the request as a valid strobe together with a skip flag, a start index and a segment-enable mask.

An output stage state machine has three states:
- `OUT_IDLE`: no answer this cycle.
- `OUT_PLACE`: a start and a mask are presented.
- `OUT_SKIP`: an all-zero line was reported.

On every clock the output stage moves to a state chosen by the current request, from whichever state it is in:
- no request goes to `OUT_IDLE`;
- a request with the zero flag goes to `OUT_SKIP`;
- any other request goes to `OUT_PLACE`.

Each tracked line has a state machine with two states:
- `BLK_FRESH`: the line has never been written.
- `BLK_WRITTEN`: the line has been written at least once.

The per-line transitions are as follows:
- A placed write moves `BLK_FRESH` to `BLK_WRITTEN`.
- A placed write keeps `BLK_WRITTEN` in `BLK_WRITTEN` and updates its end pointer.
- A skipped request causes no transition.

Top module: `seg_rot_sel`

## Requirements
- R1: While reset is asserted and after it is released, with no request, `out_valid` is 0, and every tracked line starts in the never-written state.
- R2: The first placed write to a never-written line starts at segment 0.
- R3: A placed write to a previously written line is tried first at segment (last end segment + 1) mod 4, and starts there when the data fits.
- R4: Data of N segments fits from segment s only when s + N <= 4. If it does not fit at the first candidate, the start steps forward cyclically (+1 mod 4) to the first candidate that fits. Reaching segment 0 always succeeds.
- R5: A request with `req_zero`=1 gives `out_valid`=1, `out_skip`=1, `out_start`=0 and `out_mask`=0. It leaves the line's state and end pointer unchanged, so the next placed write to that line behaves as if the zero request never happened.
- R6: After a placed write, the line's end pointer becomes start + N - 1, the last segment the data occupies.
- R7: `req_len_m1` encodes the length as N - 1 (0 means 1 segment, 3 means 4 segments). Bit i of `out_mask` enables segment i. For a placed write, bits start through start+N-1 are 1 and all other bits are 0, and `out_skip` is 0.
- R8: A request sampled at a rising edge is answered in the cycle that follows that edge. Back-to-back requests to the same line see each other's pointer updates, and `out_valid` is 0 in any cycle that follows an edge with no request.
- R9: Each tracked line keeps its own state and end pointer; writes to one line do not change the placement chosen for another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A placement request is present this cycle |
| req_blk | input | 4 | Index of the tracked line being written |
| req_zero | input | 1 | The line's data is all zero; skip placement |
| req_len_m1 | input | 2 | Compressed length in segments, minus one |
| out_valid | output | 1 | Answer for the previous cycle's request |
| out_skip | output | 1 | The request was an all-zero line and was not placed |
| out_start | output | 2 | First segment the data occupies |
| out_mask | output | 4 | Segment enables, bit i for segment i |

## Verification
A corrupted end pointer or a line wrongly held in the never-written state does not show up on the write that corrupts it. It shows up on the next placed write to the same line, as a wrong `out_start` and a shifted `out_mask` one cycle after that request. The directed scenarios therefore always follow each state-changing write, or zero-line skip, with another write to the same line. They compare its start and mask against an independent reference of the rotation and the cyclic fit search. Faults in the output stage, such as a lost strobe or a skip reported as a placement, are visible one cycle after the offending request.

// File: rtl/seg_rot_pkg.sv
`timescale 1ns/1ps
package seg_rot_pkg;

    typedef enum logic {
        BLK_FRESH   = 1'b0,
        BLK_WRITTEN = 1'b1
    } blk_state_e;

    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_PLACE = 2'd1,
        OUT_SKIP  = 2'd2
    } out_state_e;

endpackage

// File: rtl/seg_rot_fit.sv
`timescale 1ns/1ps
// Cyclic search for the first start segment, from a base, at which the
// data fits without wrapping past the top of the line.
module seg_rot_fit #(
    parameter int NUM_SEGS = 4,
    localparam int SEG_W = $clog2(NUM_SEGS)
) (
    input  logic [SEG_W-1:0] base_seg,
    input  logic [SEG_W-1:0] len_m1,
    output logic [SEG_W-1:0] start_seg
);
    localparam int EXT_W = SEG_W + 1;
    localparam logic [EXT_W-1:0] SEG_LIMIT = EXT_W'(NUM_SEGS);

    logic [SEG_W-1:0] cand [NUM_SEGS];
    logic [NUM_SEGS-1:0] fits;

    for (genvar k = 0; k < NUM_SEGS; k++) begin : g_cand
        // candidate wraps naturally modulo NUM_SEGS (power of two)
        assign cand[k] = base_seg + SEG_W'(k);
        assign fits[k] = ({1'b0, cand[k]} + {1'b0, len_m1}) < SEG_LIMIT;
    end

    always_comb begin
        start_seg = '0;
        for (int k = NUM_SEGS - 1; k >= 0; k--) begin
            if (fits[k]) begin
                start_seg = cand[k];
            end
        end
    end

    // Segment 0 always fits, so some candidate must succeed
    always_comb begin
        assert (fits != '0) else $error("AST_FIT_FOUND violated"); // R4
    end

endmodule

// File: rtl/seg_rot_mask.sv
`timescale 1ns/1ps
// Contiguous segment-enable mask from a start segment and a length.
module seg_rot_mask #(
    parameter int NUM_SEGS = 4,
    localparam int SEG_W = $clog2(NUM_SEGS)
) (
    input  logic [SEG_W-1:0]    start_seg,
    input  logic [SEG_W-1:0]    len_m1,
    output logic [NUM_SEGS-1:0] seg_en
);
    localparam int EXT_W = SEG_W + 1;

    logic [EXT_W-1:0] end_ext;
    assign end_ext = {1'b0, start_seg} + {1'b0, len_m1};

    for (genvar i = 0; i < NUM_SEGS; i++) begin : g_bit
        assign seg_en[i] = (EXT_W'(i) >= {1'b0, start_seg}) && (EXT_W'(i) <= end_ext);
    end

endmodule

// File: rtl/seg_rot_ptr_tbl.sv
`timescale 1ns/1ps
// Per-line state and last-end-segment pointer.
module seg_rot_ptr_tbl
    import seg_rot_pkg::*;
#(
    parameter int NUM_BLKS = 16,
    parameter int NUM_SEGS = 4,
    localparam int BLK_W = $clog2(NUM_BLKS),
    localparam int SEG_W = $clog2(NUM_SEGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] rd_idx,
    output blk_state_e       rd_state,
    output logic [SEG_W-1:0] rd_last,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_idx,
    input  logic [SEG_W-1:0] wr_last
);
    blk_state_e       state_q [NUM_BLKS];
    logic [SEG_W-1:0] last_q  [NUM_BLKS];
    blk_state_e       wr_next;

    assign rd_state = state_q[rd_idx];
    assign rd_last  = last_q[rd_idx];

    always_comb begin
        unique case (state_q[wr_idx])
            BLK_FRESH:   wr_next = BLK_WRITTEN;
            BLK_WRITTEN: wr_next = BLK_WRITTEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BLKS; i++) begin
                state_q[i] <= BLK_FRESH;
                last_q[i]  <= '0;
            end
        end else if (wr_en) begin
            state_q[wr_idx] <= wr_next;
            last_q[wr_idx]  <= wr_last;
        end
    end

    AST_WRITE_MARKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state_q[$past(wr_idx)] == BLK_WRITTEN)) else $error("AST_WRITE_MARKS_LINE"); // R3
    AST_POINTER_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (last_q[$past(wr_idx)] == $past(wr_last))) else $error("AST_POINTER_STORED"); // R6

endmodule

// File: rtl/seg_rot_sel.sv
`timescale 1ns/1ps
// Rotating segment write-start selector, top level.
module seg_rot_sel
    import seg_rot_pkg::*;
#(
    parameter int NUM_BLKS = 16,
    parameter int NUM_SEGS = 4,
    localparam int BLK_W = $clog2(NUM_BLKS),
    localparam int SEG_W = $clog2(NUM_SEGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [BLK_W-1:0]    req_blk,
    input  logic                req_zero,
    input  logic [SEG_W-1:0]    req_len_m1,
    output logic                out_valid,
    output logic                out_skip,
    output logic [SEG_W-1:0]    out_start,
    output logic [NUM_SEGS-1:0] out_mask
);
    localparam int EXT_W = SEG_W + 1;

    blk_state_e          rd_state;
    logic [SEG_W-1:0]    rd_last;
    logic [SEG_W-1:0]    base_seg;
    logic [SEG_W-1:0]    pick_start;
    logic [NUM_SEGS-1:0] pick_mask;
    logic [SEG_W-1:0]    pick_end;
    logic                place_now;

    out_state_e          ost_q, ost_d;
    logic [SEG_W-1:0]    start_q;
    logic [NUM_SEGS-1:0] mask_q;

    seg_rot_ptr_tbl #(.NUM_BLKS(NUM_BLKS), .NUM_SEGS(NUM_SEGS)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_blk),
        .rd_state (rd_state),
        .rd_last  (rd_last),
        .wr_en    (place_now),
        .wr_idx   (req_blk),
        .wr_last  (pick_end)
    );

    // First candidate: segment 0 for a fresh line, else one past the last end
    assign base_seg = (rd_state == BLK_FRESH) ? '0 : rd_last + SEG_W'(1);

    seg_rot_fit #(.NUM_SEGS(NUM_SEGS)) u_fit (
        .base_seg  (base_seg),
        .len_m1    (req_len_m1),
        .start_seg (pick_start)
    );

    seg_rot_mask #(.NUM_SEGS(NUM_SEGS)) u_mask (
        .start_seg (pick_start),
        .len_m1    (req_len_m1),
        .seg_en    (pick_mask)
    );

    assign pick_end  = pick_start + req_len_m1;
    assign place_now = req_valid && !req_zero;

    // Next output state
    always_comb begin
        if (!req_valid) begin
            ost_d = OUT_IDLE;
        end else if (req_zero) begin
            ost_d = OUT_SKIP;
        end else begin
            ost_d = OUT_PLACE;
        end
    end

    // State register with captured placement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ost_q   <= OUT_IDLE;
            start_q <= '0;
            mask_q  <= '0;
        end else begin
            ost_q <= ost_d;
            if (place_now) begin
                start_q <= pick_start;
                mask_q  <= pick_mask;
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (ost_q)
            OUT_IDLE: begin
                out_valid = 1'b0;
                out_skip  = 1'b0;
                out_start = '0;
                out_mask  = '0;
            end
            OUT_PLACE: begin
                out_valid = 1'b1;
                out_skip  = 1'b0;
                out_start = start_q;
                out_mask  = mask_q;
            end
            OUT_SKIP: begin
                out_valid = 1'b1;
                out_skip  = 1'b1;
                out_start = '0;
                out_mask  = '0;
            end
            default: begin
                out_valid = 1'b0;
                out_skip  = 1'b0;
                out_start = '0;
                out_mask  = '0;
            end
        endcase
    end

    AST_VALID_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid)) else $error("AST_VALID_FROM_REQ"); // R8
    AST_SKIP_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_skip) |-> (out_mask == '0)) else $error("AST_SKIP_NO_MASK"); // R5
    AST_SKIP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_skip == $past(req_zero))) else $error("AST_SKIP_FROM_ZERO"); // R5
    AST_MASK_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_skip) |-> out_mask[out_start]) else $error("AST_MASK_AT_START"); // R7
    AST_MASK_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_skip) |-> (int'($countones(out_mask)) == int'($past(req_len_m1)) + 1))
        else $error("AST_MASK_SIZE"); // R7
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_skip) |->
        (({1'b0, out_start} + {1'b0, $past(req_len_m1)}) < EXT_W'(NUM_SEGS))) else $error("AST_NO_WRAP"); // R4
    AST_FRESH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (place_now && rd_state == BLK_FRESH) |=> (out_start == '0)) else $error("AST_FRESH_AT_ZERO"); // R2

endmodule

// File: tb/seg_rot_sel_tb_top.sv
`timescale 1ns/1ps
module seg_rot_sel_tb_top;

    localparam int NB = 16;
    localparam int NS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_blk = '0;
    logic       req_zero = 1'b0;
    logic [1:0] req_len_m1 = '0;
    logic       out_valid;
    logic       out_skip;
    logic [1:0] out_start;
    logic [3:0] out_mask;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    bit ref_written [NB];
    int ref_last    [NB];

    always #2 clk = ~clk;

    seg_rot_sel #(.NUM_BLKS(NB), .NUM_SEGS(NS)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_blk    (req_blk),
        .req_zero   (req_zero),
        .req_len_m1 (req_len_m1),
        .out_valid  (out_valid),
        .out_skip   (out_skip),
        .out_start  (out_start),
        .out_mask   (out_mask)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference placement: returns start and mask, updates model when placed
    function automatic void model(int blk, bit zero, int lm1, output int st, output int mask);
        int base;
        st = 0;
        mask = 0;
        if (zero) return;
        base = ref_written[blk] ? (ref_last[blk] + 1) % NS : 0;
        for (int k = 0; k < NS; k++) begin
            int c = (base + k) % NS;
            if (c + lm1 + 1 <= NS) begin
                st = c;
                break;
            end
        end
        for (int i = st; i <= st + lm1; i++) mask |= (1 << i);
        ref_written[blk] = 1'b1;
        ref_last[blk] = st + lm1;
    endfunction

    // One request, answered in the following cycle
    task automatic do_req(int blk, bit zero, int lm1, string req, output int got_start);
        int est, emask;
        @(negedge clk);
        req_valid  = 1'b1;
        req_blk    = 4'(blk);
        req_zero   = zero;
        req_len_m1 = 2'(lm1);
        @(negedge clk);
        req_valid = 1'b0;
        model(blk, zero, lm1, est, emask);
        got_start = int'(out_start);
        check(req, "valid", int'(out_valid), 1);
        check(req, "skip",  int'(out_skip), int'(zero));
        check(req, "start", int'(out_start), est);
        check(req, "mask",  int'(out_mask), emask);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < NB; i++) begin
            ref_written[i] = 1'b0;
            ref_last[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "valid idle", int'(out_valid), 0);
    endtask

    task automatic t_first_write();
        int s;
        // R2: fresh lines start at 0 for every length
        for (int b = 0; b < 4; b++) begin
            do_req(b, 1'b0, b, "R2", s);
            check("R2", "explicit start", s, 0);
        end
    endtask

    task automatic t_rotate();
        int s;
        // R3 R6: single-segment writes march 0,1,2,3 then back to 0
        for (int n = 0; n < 5; n++) begin
            do_req(9, 1'b0, 0, "R3", s);
            check("R6", "explicit start", s, n % NS);
        end
    endtask

    task automatic t_wrap();
        int s;
        // R4: line 10, len2 -> 0 (end1); len3 base2 -> 0 (end2); len4 base3 -> 0; len1 base0 -> 0
        do_req(10, 1'b0, 1, "R4", s);
        do_req(10, 1'b0, 2, "R4", s);
        check("R4", "len3 wraps to 0", s, 0);
        do_req(10, 1'b0, 3, "R4", s);
        check("R4", "len4 wraps to 0", s, 0);
        do_req(10, 1'b0, 0, "R4", s);
        // end now 0: len3 from base1 fits at 1
        do_req(10, 1'b0, 2, "R4", s);
        check("R4", "len3 fits at 1", s, 1);
    endtask

    task automatic t_zero();
        int s;
        // R5: zero line leaves pointer; next write continues rotation
        do_req(11, 1'b0, 0, "R5", s);
        do_req(11, 1'b1, 2, "R5", s);
        do_req(11, 1'b0, 0, "R5", s);
        check("R5", "pointer kept", s, 1);
        // R5: zero on a fresh line keeps it fresh
        do_req(12, 1'b1, 0, "R5", s);
        do_req(12, 1'b0, 1, "R5", s);
        check("R5", "fresh kept", s, 0);
    endtask

    task automatic t_mask();
        int s;
        // R7: sweep all lengths from varying starts
        for (int n = 0; n < 12; n++) begin
            do_req(13, 1'b0, (n * 3 + 1) % NS, "R7", s);
        end
    endtask

    task automatic t_indep();
        int s;
        // R9: interleave two lines
        do_req(14, 1'b0, 0, "R9", s);
        do_req(15, 1'b0, 1, "R9", s);
        do_req(14, 1'b0, 0, "R9", s);
        check("R9", "line14 second", s, 1);
        do_req(15, 1'b0, 0, "R9", s);
        check("R9", "line15 second", s, 2);
    endtask

    task automatic t_back_to_back();
        int est, emask;
        // R8: consecutive requests to one line, one per cycle
        @(negedge clk);
        req_valid = 1'b1; req_blk = 4'd5; req_zero = 1'b0; req_len_m1 = 2'd1;
        @(negedge clk);
        model(5, 1'b0, 1, est, emask);
        check("R8", "b2b first valid", int'(out_valid), 1);
        check("R8", "b2b first start", int'(out_start), est);
        req_len_m1 = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        model(5, 1'b0, 0, est, emask);
        check("R8", "b2b second valid", int'(out_valid), 1);
        check("R8", "b2b second start", int'(out_start), est);
        check("R8", "b2b second mask", int'(out_mask), emask);
        @(negedge clk);
        check("R8", "valid drops", int'(out_valid), 0);
    endtask

    initial begin
        t_reset();
        t_first_write();
        t_rotate();
        t_wrap();
        t_zero();
        t_mask();
        t_indep();
        t_back_to_back();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule